// File: doc/BRIEF.md
# Power-Good and Thermal Supervisor

This block decides when a boost regulator may report its output as good and when it must shut down for heat. It drives `pg_n`, the pull-down enable of an open-drain power-good line (1 = pull the line low, 0 = release it), and `otp_shutdown`, a request to stop the converter. It takes a one-cycle strobe when soft-start finishes, a fault flag from the main controller, a current-limit flag from the synchronous rectifier, a periodic time-base tick, and four comparator flags from a die-temperature sensor.

Power good can be removed for three separate reasons, each with its own return rule. A fault drops it and forces a new soft-start completion before it may return. A current limit that stays on for a run of ticks drops it only while the limit remains on. A warm die drops it with a wide temperature hysteresis band. A second, higher thermal threshold drives the shutdown request, which has a hysteresis band of its own. Taking the enable input low clears all of this state.

Top module: `pgood_thermal_sup`

## Requirements
- R1: While `enable` is 0, and after reset, `pg_n` is 1 and `otp_shutdown` is 0.
- R2: `pg_n` goes to 0 only once a `ss_done` strobe has been seen while enabled and free of faults. Before that strobe it stays 1.
- R3: When `ilim_act` stays at 1 for `ILIM_TICKS` ticks in a row (default 64), `pg_n` goes to 1 at the edge that samples the last of those ticks. One tick fewer leaves it at 0.
- R4: Whenever `ilim_act` drops to 0, the tick run count restarts from zero.
- R5: The current-limit cause lifts as soon as `ilim_act` returns to 0. No new strobe is needed for that.
- R6: `temp_gt120` = 1 forces `pg_n` to 1. This cause holds while the die is between the thresholds, and lifts only when `temp_lt100` = 1.
- R7: `fault_act` = 1 forces `pg_n` to 1. After the fault clears, `pg_n` stays 1 until a new `ss_done` strobe arrives. A strobe in the same cycle as the fault is ignored.
- R8: `otp_shutdown` rises when `temp_gt150` = 1 and stays at 1 while `temp_gt130` = 1. It clears once `temp_gt130` = 0.
- R9: A cycle with `enable` = 0 clears the tick run count, the warm latch and the shutdown latch.
- R10: Both outputs are registered. An input sampled at a rising edge shows on the outputs just after that edge, never earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; 0 clears all state |
| ss_done | input | 1 | One-cycle strobe: soft-start finished |
| fault_act | input | 1 | A converter fault is active |
| ilim_act | input | 1 | Rectifier current limit is active |
| tick | input | 1 | Time-base tick for the persistence count |
| temp_gt150 | input | 1 | Die above 150 °C |
| temp_gt130 | input | 1 | Die above 130 °C |
| temp_gt120 | input | 1 | Die above 120 °C |
| temp_lt100 | input | 1 | Die below 100 °C |
| pg_n | output | 1 | Power-good pull-down enable (1 = not good) |
| otp_shutdown | output | 1 | Thermal shutdown request |

## Verification
The soft-start strobe and a new fault can land in the same cycle. The fault must win, so the strobe is lost and a second strobe is needed later. The bench raises `ss_done` and `fault_act` together, then clears the fault. It checks that `pg_n` stays at 1 and falls only after a later, separate strobe. In the same way, a heat event and a cycle with `enable` at 0 are made to overlap. The check is that the enable clear wipes the warm latch even though the die never reported below 100 °C.

// File: rtl/sup_pkg.sv
package sup_pkg;
   typedef struct packed {
      logic gt150;
      logic gt130;
      logic gt120;
      logic lt100;
   } temp_flags_t;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/sup_persist.sv
module sup_persist
   import sup_pkg::*;
#(
   parameter int unsigned LIMIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic act,
   input  logic tick,
   output logic trip_d
);
   localparam int unsigned CW = cnt_width(LIMIT);
   localparam logic [CW-1:0] LAST = CW'(LIMIT);
   localparam logic [CW-1:0] PRE  = CW'(LIMIT - 1);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("sup_persist: LIMIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] run_q, run_d;

   always_comb begin
      run_d = run_q;
      if (!en || !act) begin
         run_d = '0;
      end else if (tick && (run_q != LAST)) begin
         run_d = run_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= '0;
      else        run_q <= run_d;
   end

   assign trip_d = en && act && ((run_q == LAST) || (tick && (run_q == PRE)));
endmodule

// File: rtl/sup_hyst_latch.sv
module sup_hyst_latch #(
   parameter bit SET_WINS = 1'b1,
   parameter bit OUT_NEXT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic set_i,
   input  logic clr_i,
   output logic state_o
);
   logic st_q, st_d;

   generate
      if (SET_WINS) begin : g_set_first
         always_comb begin
            if (!en)        st_d = 1'b0;
            else if (set_i) st_d = 1'b1;
            else if (clr_i) st_d = 1'b0;
            else            st_d = st_q;
         end
      end else begin : g_clr_first
         always_comb begin
            if (!en)        st_d = 1'b0;
            else if (clr_i) st_d = 1'b0;
            else if (set_i) st_d = 1'b1;
            else            st_d = st_q;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= 1'b0;
      else        st_q <= st_d;
   end

   generate
      if (OUT_NEXT) begin : g_out_next
         assign state_o = st_d;
      end else begin : g_out_reg
         assign state_o = st_q;
      end
   endgenerate
endmodule

// File: rtl/sup_pg_seq.sv
module sup_pg_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic ss_done,
   input  logic fault,
   input  logic block_i,
   output logic pg_n
);
   logic armed_q, armed_d;

   always_comb begin
      armed_d = en && !fault && (armed_q || ss_done);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         pg_n    <= 1'b1;
      end else begin
         armed_q <= armed_d;
         pg_n    <= !(armed_d && !block_i);
      end
   end
endmodule

// File: rtl/pgood_thermal_sup.sv
module pgood_thermal_sup
   import sup_pkg::*;
#(
   parameter int unsigned ILIM_TICKS    = 64,
   parameter bit          HYST_SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic ss_done,
   input  logic fault_act,
   input  logic ilim_act,
   input  logic tick,
   input  logic temp_gt150,
   input  logic temp_gt130,
   input  logic temp_gt120,
   input  logic temp_lt100,
   output logic pg_n,
   output logic otp_shutdown
);
   temp_flags_t tf;
   logic ilim_trip_d;
   logic warm_d;
   logic otp_q;

   assign tf = '{gt150: temp_gt150, gt130: temp_gt130,
                 gt120: temp_gt120, lt100: temp_lt100};

   sup_persist #(.LIMIT(ILIM_TICKS)) u_ilim (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (enable),
      .act   (ilim_act),
      .tick  (tick),
      .trip_d(ilim_trip_d)
   );

   sup_hyst_latch #(.SET_WINS(HYST_SET_WINS), .OUT_NEXT(1'b1)) u_warm (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (enable),
      .set_i  (tf.gt120),
      .clr_i  (tf.lt100),
      .state_o(warm_d)
   );

   sup_hyst_latch #(.SET_WINS(HYST_SET_WINS), .OUT_NEXT(1'b0)) u_otp (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (enable),
      .set_i  (tf.gt150),
      .clr_i  (!tf.gt130),
      .state_o(otp_q)
   );

   sup_pg_seq u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (enable),
      .ss_done(ss_done),
      .fault  (fault_act),
      .block_i(ilim_trip_d || warm_d),
      .pg_n   (pg_n)
   );

   assign otp_shutdown = otp_q;
endmodule

// File: rtl/pgood_thermal_sup_chk.sv
module pgood_thermal_sup_chk
   import sup_pkg::*;
#(
   parameter int unsigned ILIM_TICKS = 64
) (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic fault_act,
   input logic ilim_act,
   input logic tick,
   input logic temp_gt150,
   input logic temp_gt130,
   input logic temp_gt120,
   input logic temp_lt100,
   input logic pg_n,
   input logic otp_shutdown
);
   localparam int unsigned CW = cnt_width(ILIM_TICKS);
   logic [CW-1:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    run <= '0;
      else if (!enable || !ilim_act) run <= '0;
      else if (tick && run != CW'(ILIM_TICKS)) run <= run + 1'b1;
   end

   a_r1_disable_pg: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> pg_n);
   a_r1_disable_otp: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !otp_shutdown);
   a_r7_fault_pg: assert property (@(posedge clk) disable iff (!rst_n)
      fault_act |=> pg_n);
   a_r6_warm_pg: assert property (@(posedge clk) disable iff (!rst_n)
      (temp_gt120 && !temp_lt100) |=> pg_n);
   a_r8_otp_set: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && temp_gt150 && temp_gt130) |=> otp_shutdown);
   a_r8_otp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && otp_shutdown && temp_gt130) |=> otp_shutdown);
   a_r8_otp_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (!temp_gt150 && !temp_gt130) |=> !otp_shutdown);
   a_r3_ilim_trip: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && ilim_act && ((run == CW'(ILIM_TICKS)) ||
         (tick && run == CW'(ILIM_TICKS - 1)))) |=> pg_n);
endmodule

bind pgood_thermal_sup pgood_thermal_sup_chk #(.ILIM_TICKS(ILIM_TICKS)) u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .fault_act(fault_act),
   .ilim_act(ilim_act), .tick(tick), .temp_gt150(temp_gt150),
   .temp_gt130(temp_gt130), .temp_gt120(temp_gt120), .temp_lt100(temp_lt100),
   .pg_n(pg_n), .otp_shutdown(otp_shutdown)
);

// File: tb/pgood_thermal_sup_tb.sv
`timescale 1ns/1ps
module pgood_thermal_sup_tb;
   localparam int unsigned N = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b1, ss_done = 1'b0, fault_act = 1'b0, ilim_act = 1'b0, tick = 1'b0;
   logic temp_gt150 = 1'b0, temp_gt130 = 1'b0, temp_gt120 = 1'b0, temp_lt100 = 1'b0;
   logic pg_n, otp_shutdown;
   int tests = 0, fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pgood_thermal_sup #(.ILIM_TICKS(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .ss_done(ss_done),
      .fault_act(fault_act), .ilim_act(ilim_act), .tick(tick),
      .temp_gt150(temp_gt150), .temp_gt130(temp_gt130),
      .temp_gt120(temp_gt120), .temp_lt100(temp_lt100),
      .pg_n(pg_n), .otp_shutdown(otp_shutdown)
   );

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic check(input string req, input logic act, input logic exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic strobe_ss();
      ss_done = 1'b1;
      step();
      ss_done = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 pg_n after reset", pg_n, 1'b1);
      check("R1 otp after reset", otp_shutdown, 1'b0);
   endtask

   task automatic t_release();
      step(3);
      check("R2 no strobe yet", pg_n, 1'b1);
      ss_done = 1'b1;
      check("R10 no change before edge", pg_n, 1'b1);
      step();
      ss_done = 1'b0;
      check("R2 released after strobe", pg_n, 1'b0);
   endtask

   task automatic t_ilim_persist();
      ilim_act = 1'b1; tick = 1'b1;
      step(N - 1);
      check("R3 one tick short", pg_n, 1'b0);
      step();
      check("R3 limit persisted", pg_n, 1'b1);
      ilim_act = 1'b0; tick = 1'b0;
      step();
      check("R5 returns when limit drops", pg_n, 1'b0);
   endtask

   task automatic t_ilim_restart();
      ilim_act = 1'b1; tick = 1'b1;
      step(N - 1);
      ilim_act = 1'b0;
      step();
      ilim_act = 1'b1;
      step(N - 1);
      check("R4 count restarted", pg_n, 1'b0);
      step();
      check("R4 full run after restart", pg_n, 1'b1);
      ilim_act = 1'b0; tick = 1'b0;
      step();
   endtask

   task automatic t_warm();
      temp_gt120 = 1'b1;
      step();
      check("R6 warm drops pg", pg_n, 1'b1);
      temp_gt120 = 1'b0;
      step(5);
      check("R6 held in band", pg_n, 1'b1);
      temp_lt100 = 1'b1;
      step();
      check("R6 cooled returns pg", pg_n, 1'b0);
      temp_lt100 = 1'b0;
   endtask

   task automatic t_fault();
      fault_act = 1'b1;
      step();
      check("R7 fault drops pg", pg_n, 1'b1);
      fault_act = 1'b0;
      step(3);
      check("R7 stays low after fault", pg_n, 1'b1);
      fault_act = 1'b1; ss_done = 1'b1;
      step();
      ss_done = 1'b0; fault_act = 1'b0;
      step(2);
      check("R7 strobe with fault ignored", pg_n, 1'b1);
      strobe_ss();
      check("R7 new strobe rearms", pg_n, 1'b0);
   endtask

   task automatic t_otp();
      temp_gt150 = 1'b1; temp_gt130 = 1'b1; temp_gt120 = 1'b1;
      step();
      check("R8 otp set", otp_shutdown, 1'b1);
      check("R6 pg low when hot", pg_n, 1'b1);
      temp_gt150 = 1'b0;
      step(3);
      check("R8 otp held above 130", otp_shutdown, 1'b1);
      temp_gt130 = 1'b0;
      step();
      check("R8 otp cleared below 130", otp_shutdown, 1'b0);
      temp_gt120 = 1'b0; temp_lt100 = 1'b1;
      step();
      temp_lt100 = 1'b0;
      check("R6 pg back after cooling", pg_n, 1'b0);
   endtask

   task automatic t_disable();
      temp_gt150 = 1'b1; temp_gt130 = 1'b1; temp_gt120 = 1'b1;
      step();
      check("R8 otp set again", otp_shutdown, 1'b1);
      enable = 1'b0;
      step();
      check("R1 disable pg", pg_n, 1'b1);
      check("R1 disable otp", otp_shutdown, 1'b0);
      temp_gt150 = 1'b0; temp_gt130 = 1'b0; temp_gt120 = 1'b0;
      enable = 1'b1;
      strobe_ss();
      check("R9 warm latch cleared", pg_n, 1'b0);
      check("R9 otp latch cleared", otp_shutdown, 1'b0);
      ilim_act = 1'b1; tick = 1'b1;
      step(N - 1);
      enable = 1'b0;
      step();
      enable = 1'b1; ss_done = 1'b1;
      step();
      ss_done = 1'b0;
      step(N - 2);
      check("R9 count cleared by disable", pg_n, 1'b0);
      step();
      check("R9 full run after enable", pg_n, 1'b1);
      ilim_act = 1'b0; tick = 1'b0;
      step();
   endtask

   initial begin
      step(2);
      rst_n = 1'b1;
      step();
      t_reset();
      t_release();
      t_ilim_persist();
      t_ilim_restart();
      t_warm();
      t_fault();
      t_otp();
      t_disable();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule